// File: doc/BRIEF.md
# NAND Flash Host Bridge

This block sits between a 16-bit processor bus and an 8-bit NAND flash device. Software sees a small set of byte-wide registers: a data port, a mode byte, a status byte, an interrupt status byte and an interrupt mask byte. The mode byte drives the chip-enable, command-latch and address-latch lines directly. A particular value of the mode byte therefore puts every data-port access into command, address or data cycles, or puts the device into standby.

A data-port access of either width becomes one or two NAND byte cycles. Each byte cycle is one write-enable or read-enable pulse of fixed length, followed by a fixed recovery gap. Wide accesses pack the first byte on the wire into bits 7:0 and the second into bits 15:8. The bus is held off with a wait signal until every byte cycle of the access has finished. The device ready/busy line is synchronized into the clock domain. The line is reported in status, and its rising edge latches a ready interrupt that the mask can route to the interrupt output.

Top module: `nand_bridge`

## Requirements
- R1: After reset, chip enable is inactive (nf_ce_n=1), nf_cle=0, nf_ale=0, nf_we_n=1, nf_re_n=1, bus_wait=0, irq=0 and nf_pwr_en=0.
- R2: The mode register sits at offset 4 and reads back what was written. Its bit 4 makes chip enable active (nf_ce_n=0), bit 0 drives nf_cle and bit 1 drives nf_ale. So 0x94 selects data cycles, 0x95 command cycles, 0x96 address cycles and 0x00 standby.
- R3: In command mode (0x95), a byte-wide write to the data port at offset 0 issues exactly one write-enable pulse with nf_cle high, carrying bus_wdata[7:0] on nf_dq_out (for example 0xFF).
- R4: A wide write to the data port issues two write-enable pulses: bits 7:0 first, then bits 15:8.
- R5: A wide read of the data port issues two read-enable pulses and returns the first byte in bits 7:0 and the second in bits 15:8. A byte-wide read issues one pulse and returns zero in bits 15:8.
- R6: Every write-enable or read-enable pulse lasts exactly PULSE_CLKS clocks. The two strobes are never low together, and nf_dq_oe is never high while nf_re_n is low.
- R7: bus_wait rises on the clock edge that accepts a data-port access and falls one clock after the last recovery gap. That makes 2*(PULSE_CLKS+RECOV_CLKS)+1 cycles for a wide access and PULSE_CLKS+RECOV_CLKS+1 cycles for a byte access. A request made while bus_wait is high is ignored.
- R8: Status (offset 5) bit 7 reads 1 while the synchronized ready/busy line is low (busy) and 0 when it is high.
- R9: A rising edge on the synchronized ready/busy line sets interrupt status (offset 6) bit 0. Writing that register clears each flag whose data bit is 1, so 0x0F clears all.
- R10: irq is high one clock after the ready flag is set while mask (offset 7) bits 7 and 0 are both 1 (value 0x81). It is low whenever either mask bit is clear.
- R11: Writing 0x0C to the mode register turns nf_pwr_en on and writing 0x08 turns it off. Any other mode value leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | One-cycle access request, taken when bus_wait is low |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_wide | input | 1 | 1 = 16-bit data-port access, 0 = byte |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid once bus_wait is low after a read |
| bus_wait | output | 1 | High while a data-port access is in progress |
| irq | output | 1 | Ready interrupt |
| nf_ce_n | output | 1 | NAND chip enable, active low |
| nf_cle | output | 1 | Command latch enable |
| nf_ale | output | 1 | Address latch enable |
| nf_we_n | output | 1 | Write enable strobe, active low |
| nf_re_n | output | 1 | Read enable strobe, active low |
| nf_dq_out | output | 8 | Byte driven to the device |
| nf_dq_oe | output | 1 | Output enable for nf_dq_out |
| nf_dq_in | input | 8 | Byte from the device |
| nf_rb | input | 1 | Device ready (1) / busy (0), asynchronous |
| nf_pwr_en | output | 1 | Media power enable |

## Verification
The assertions take for granted that bus_req is a single-cycle pulse. They also assume the address and write data stay steady only in that cycle, since the block registers all it needs at acceptance. nf_rb is treated as asynchronous but slow. The pulse-width and strobe-exclusion checks assume nothing about it beyond the synchronizer. The bench drives every input on the falling clock edge and raises requests only after bus_wait has dropped, except in the one deliberate overlap test. It changes nf_rb only with several idle cycles before the next status read, so the two-flop delay never makes a check ambiguous.

// File: rtl/nand_bridge_pkg.sv
package nand_bridge_pkg;
  localparam logic [2:0] OFS_DATA   = 3'd0;
  localparam logic [2:0] OFS_MODE   = 3'd4;
  localparam logic [2:0] OFS_STATUS = 3'd5;
  localparam logic [2:0] OFS_ISR    = 3'd6;
  localparam logic [2:0] OFS_MASK   = 3'd7;

  localparam int MB_CLE = 0;
  localparam int MB_ALE = 1;
  localparam int MB_CE  = 4;
  localparam int MK_RDY = 0;
  localparam int MK_EN  = 7;
  localparam int ST_BUSY = 7;

  localparam logic [7:0] PWR_ON_CODE  = 8'h0C;
  localparam logic [7:0] PWR_OFF_CODE = 8'h08;

  typedef enum logic [1:0] {S_IDLE, S_LOW, S_HIGH} seq_state_t;
endpackage

// File: rtl/nand_rb_sync.sv
module nand_rb_sync (
  input  logic clk,
  input  logic rst,
  input  logic rb_in,
  output logic rb_level,
  output logic rb_rise
);
  logic s1, s2, prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= 1'b1; s2 <= 1'b1; prev <= 1'b1;
    end else begin
      s1 <= rb_in; s2 <= s1; prev <= s2;
    end
  end

  assign rb_level = s2;
  assign rb_rise  = s2 & ~prev;
endmodule

// File: rtl/nand_byte_seq.sv
module nand_byte_seq
  import nand_bridge_pkg::*;
#(
  parameter int PULSE_CLKS = 3,
  parameter int RECOV_CLKS = 2,
  parameter int NW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          wr,
  input  logic          wide,
  input  logic [2*NW-1:0] wdata,
  input  logic [NW-1:0] dq_in,
  output logic          we_n,
  output logic          re_n,
  output logic [NW-1:0] dq_out,
  output logic          dq_oe,
  output logic          done,
  output logic [2*NW-1:0] rdata,
  output logic          busy
);
  localparam int MAXC = (PULSE_CLKS > RECOV_CLKS) ? PULSE_CLKS : RECOV_CLKS;
  localparam int CW   = $clog2(MAXC + 2);
  localparam logic [CW-1:0] P_LAST = CW'(PULSE_CLKS - 1);
  localparam logic [CW-1:0] R_LAST = CW'(RECOV_CLKS - 1);

  seq_state_t state;
  logic [CW-1:0] cnt;
  logic          second, is_wr, is_wide;
  logic [NW-1:0] hi_byte;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_IDLE; cnt <= '0; second <= 1'b0; is_wr <= 1'b0; is_wide <= 1'b0;
      hi_byte <= '0; we_n <= 1'b1; re_n <= 1'b1; dq_out <= '0; dq_oe <= 1'b0;
      done <= 1'b0; rdata <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          state <= S_LOW; cnt <= '0; second <= 1'b0;
          is_wr <= wr; is_wide <= wide; hi_byte <= wdata[2*NW-1:NW];
          dq_out <= wdata[NW-1:0]; dq_oe <= wr;
          we_n <= ~wr; re_n <= wr; rdata <= '0;
        end
        S_LOW: if (cnt == P_LAST) begin
          we_n <= 1'b1; re_n <= 1'b1; cnt <= '0; state <= S_HIGH;
          if (!is_wr) begin
            if (second) rdata[2*NW-1:NW] <= dq_in;
            else        rdata[NW-1:0]    <= dq_in;
          end
        end else cnt <= cnt + CW'(1);
        S_HIGH: if (cnt == R_LAST) begin
          cnt <= '0;
          if (is_wide && !second) begin
            second <= 1'b1; state <= S_LOW; dq_out <= hi_byte;
            we_n <= ~is_wr; re_n <= is_wr;
          end else begin
            state <= S_IDLE; dq_oe <= 1'b0; done <= 1'b1;
          end
        end else cnt <= cnt + CW'(1);
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy = (state != S_IDLE);

  // Checker: cycles the active strobe has been low.
  logic [CW-1:0] chk_low;
  logic          any_low;
  assign any_low = ~(we_n & re_n);
  always_ff @(posedge clk) begin
    if (rst)          chk_low <= '0;
    else if (any_low) chk_low <= chk_low + CW'(1);
    else              chk_low <= '0;
  end

  a_r6_pulse_width: assert property (@(posedge clk) disable iff (rst)
    ($past(any_low) && !any_low) |-> (chk_low == CW'(PULSE_CLKS)));
  a_r6_one_strobe: assert property (@(posedge clk) disable iff (rst)
    !(~we_n && ~re_n));
  a_r6_no_drive_on_read: assert property (@(posedge clk) disable iff (rst)
    !re_n |-> !dq_oe);
endmodule

// File: rtl/nand_bridge.sv
module nand_bridge
  import nand_bridge_pkg::*;
#(
  parameter int PULSE_CLKS = 3,
  parameter int RECOV_CLKS = 2,
  parameter int NW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            bus_req,
  input  logic            bus_we,
  input  logic            bus_wide,
  input  logic [2:0]      bus_addr,
  input  logic [2*NW-1:0] bus_wdata,
  output logic [2*NW-1:0] bus_rdata,
  output logic            bus_wait,
  output logic            irq,
  output logic            nf_ce_n,
  output logic            nf_cle,
  output logic            nf_ale,
  output logic            nf_we_n,
  output logic            nf_re_n,
  output logic [NW-1:0]   nf_dq_out,
  output logic            nf_dq_oe,
  input  logic [NW-1:0]   nf_dq_in,
  input  logic            nf_rb,
  output logic            nf_pwr_en
);
  localparam int BW = 2 * NW;

  logic [7:0] mode_q, mask_q;
  logic       isr_flag, pwr_q, irq_q, wait_q, rd_pend;
  logic [BW-1:0] rdata_q, seq_rdata;
  logic       rb_level, rb_rise, seq_done, seq_busy;
  logic       acc, acc_data, acc_wr;
  logic [7:0] reg_mux;

  assign acc      = bus_req & ~wait_q;
  assign acc_data = acc && (bus_addr == OFS_DATA);
  assign acc_wr   = acc && bus_we;

  nand_rb_sync u_sync (
    .clk(clk), .rst(rst), .rb_in(nf_rb), .rb_level(rb_level), .rb_rise(rb_rise)
  );

  nand_byte_seq #(.PULSE_CLKS(PULSE_CLKS), .RECOV_CLKS(RECOV_CLKS), .NW(NW)) u_seq (
    .clk(clk), .rst(rst), .start(acc_data), .wr(bus_we), .wide(bus_wide),
    .wdata(bus_wdata), .dq_in(nf_dq_in), .we_n(nf_we_n), .re_n(nf_re_n),
    .dq_out(nf_dq_out), .dq_oe(nf_dq_oe), .done(seq_done), .rdata(seq_rdata),
    .busy(seq_busy)
  );

  always_comb begin
    case (bus_addr)
      OFS_MODE:   reg_mux = mode_q;
      OFS_STATUS: reg_mux = {~rb_level, 7'b0};
      OFS_ISR:    reg_mux = {7'b0, isr_flag};
      OFS_MASK:   reg_mux = mask_q;
      default:    reg_mux = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= 8'h00; mask_q <= 8'h00; pwr_q <= 1'b0; isr_flag <= 1'b0;
      irq_q <= 1'b0; wait_q <= 1'b0; rd_pend <= 1'b0; rdata_q <= '0;
    end else begin
      if (acc_wr && bus_addr == OFS_MODE) begin
        mode_q <= bus_wdata[7:0];
        if (bus_wdata[7:0] == PWR_ON_CODE)       pwr_q <= 1'b1;
        else if (bus_wdata[7:0] == PWR_OFF_CODE) pwr_q <= 1'b0;
      end
      if (acc_wr && bus_addr == OFS_MASK) mask_q <= bus_wdata[7:0];

      if (rb_rise) isr_flag <= 1'b1;
      else if (acc_wr && bus_addr == OFS_ISR && bus_wdata[0]) isr_flag <= 1'b0;

      irq_q <= isr_flag & mask_q[MK_RDY] & mask_q[MK_EN];

      if (acc_data)      wait_q <= 1'b1;
      else if (seq_done) wait_q <= 1'b0;

      if (acc_data) rd_pend <= ~bus_we;

      if (acc && !bus_we && !acc_data)  rdata_q <= {{(BW-8){1'b0}}, reg_mux};
      else if (seq_done && rd_pend)     rdata_q <= seq_rdata;
    end
  end

  assign bus_rdata = rdata_q;
  assign bus_wait  = wait_q;
  assign irq       = irq_q;
  assign nf_ce_n   = ~mode_q[MB_CE];
  assign nf_cle    = mode_q[MB_CLE];
  assign nf_ale    = mode_q[MB_ALE];
  assign nf_pwr_en = pwr_q;

  a_r7_wait_on_data: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !bus_wait && bus_addr == OFS_DATA) |=> bus_wait);
  a_r7_seq_covered: assert property (@(posedge clk) disable iff (rst)
    seq_busy |-> bus_wait);
  a_r9_flag_on_rise: assert property (@(posedge clk) disable iff (rst)
    rb_rise |=> isr_flag);
  a_r10_irq_gated: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(mask_q[MK_RDY] && mask_q[MK_EN]));
endmodule

// File: tb/sim_nand_bridge.sv
`timescale 1ns/1ps
module sim_nand_bridge;
  localparam int P = 3;
  localparam int R = 2;

  logic clk = 1'b0, rst = 1'b1;
  logic bus_req = 0, bus_we = 0, bus_wide = 0;
  logic [2:0] bus_addr = 0;
  logic [15:0] bus_wdata = 0, bus_rdata;
  logic bus_wait, irq, nf_ce_n, nf_cle, nf_ale, nf_we_n, nf_re_n, nf_dq_oe, nf_pwr_en;
  logic [7:0] nf_dq_out, nf_dq_in;
  logic nf_rb = 1'b1;

  always #2.5 clk = ~clk;

  nand_bridge #(.PULSE_CLKS(P), .RECOV_CLKS(R), .NW(8)) u0 (
    .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we), .bus_wide(bus_wide),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_wait(bus_wait), .irq(irq), .nf_ce_n(nf_ce_n), .nf_cle(nf_cle),
    .nf_ale(nf_ale), .nf_we_n(nf_we_n), .nf_re_n(nf_re_n), .nf_dq_out(nf_dq_out),
    .nf_dq_oe(nf_dq_oe), .nf_dq_in(nf_dq_in), .nf_rb(nf_rb), .nf_pwr_en(nf_pwr_en)
  );

  int checks = 0, fails = 0;
  bit finished = 0;

  // Simple device model
  localparam logic [7:0] RD_MEM [4] = '{8'h3C, 8'hC3, 8'h77, 8'h00};
  int rd_idx = 0;
  assign nf_dq_in = RD_MEM[rd_idx % 4];
  always @(posedge nf_re_n) if (!rst) rd_idx++;

  logic [7:0] log_byte [32];
  logic       log_cle  [32];
  logic       log_ce_n [32];
  int log_n = 0;
  always @(posedge nf_we_n) if (!rst && log_n < 32) begin
    log_byte[log_n] = nf_dq_out; log_cle[log_n] = nf_cle; log_ce_n[log_n] = nf_ce_n;
    log_n++;
  end

  int wlow = 0, rlow = 0, bad_width = 0, oe_on_read = 0, both_low = 0;
  always @(negedge clk) begin
    if (!nf_we_n) wlow++; else if (wlow != 0) begin if (wlow != P) bad_width++; wlow = 0; end
    if (!nf_re_n) rlow++; else if (rlow != 0) begin if (rlow != P) bad_width++; rlow = 0; end
    if (!nf_re_n && nf_dq_oe) oe_on_read++;
    if (!nf_re_n && !nf_we_n) both_low++;
  end

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  int wait_cycles = 0;
  task automatic acc(input bit we, input bit wide, input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_req = 1; bus_we = we; bus_wide = wide; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_req = 0;
    wait_cycles = 0;
    while (bus_wait) begin wait_cycles++; @(negedge clk); end
  endtask

  // {we, addr, wdata, expected}
  localparam int NV = 10;
  localparam logic [19:0] VEC [NV] = '{
    {1'b1, 3'd4, 8'h95, 8'h00}, {1'b0, 3'd4, 8'h00, 8'h95},
    {1'b1, 3'd7, 8'h81, 8'h00}, {1'b0, 3'd7, 8'h00, 8'h81},
    {1'b1, 3'd4, 8'h96, 8'h00}, {1'b0, 3'd4, 8'h00, 8'h96},
    {1'b0, 3'd5, 8'h00, 8'h00}, {1'b0, 3'd6, 8'h00, 8'h00},
    {1'b1, 3'd7, 8'h01, 8'h00}, {1'b0, 3'd7, 8'h00, 8'h01}
  };

  initial begin
    int base;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk("R1 ce_n", 16'(nf_ce_n), 16'd1);
    chk("R1 cle/ale", {14'd0, nf_cle, nf_ale}, 16'd0);
    chk("R1 strobes", {14'd0, nf_we_n, nf_re_n}, 16'd3);
    chk("R1 wait/irq/pwr", {13'd0, bus_wait, irq, nf_pwr_en}, 16'd0);

    // Register table (R2, R8, R9, R10 read-back)
    for (int i = 0; i < NV; i++) begin
      acc(VEC[i][19], 1'b0, VEC[i][18:16], {8'h00, VEC[i][15:8]});
      if (!VEC[i][19]) chk($sformatf("R2 table vector %0d", i), bus_rdata, {8'h00, VEC[i][7:0]});
    end

    // R2 line decode
    acc(1, 0, 3'd4, 16'h0095);
    chk("R2 cmd lines", {13'd0, nf_ce_n, nf_cle, nf_ale}, 16'b010);
    acc(1, 0, 3'd4, 16'h0096);
    chk("R2 addr lines", {13'd0, nf_ce_n, nf_cle, nf_ale}, 16'b001);
    acc(1, 0, 3'd4, 16'h0000);
    chk("R2 standby lines", {13'd0, nf_ce_n, nf_cle, nf_ale}, 16'b100);

    // R3 command byte
    acc(1, 0, 3'd4, 16'h0095);
    base = log_n;
    acc(1, 0, 3'd0, 16'h12FF);
    chk("R3 pulse count", 16'(log_n - base), 16'd1);
    chk("R3 byte/cle/ce_n", {6'd0, log_ce_n[base], log_cle[base], log_byte[base]}, {6'd0, 1'b0, 1'b1, 8'hFF});
    chk("R7 byte wait cycles", 16'(wait_cycles), 16'(P + R + 1));

    // R4 wide write
    acc(1, 0, 3'd4, 16'h0094);
    base = log_n;
    acc(1, 1, 3'd0, 16'hA55A);
    chk("R4 pulse count", 16'(log_n - base), 16'd2);
    chk("R4 byte order", {log_byte[base+1], log_byte[base]}, 16'hA55A);
    chk("R4 cle low", {15'd0, log_cle[base] | log_cle[base+1]}, 16'd0);
    chk("R7 wide wait cycles", 16'(wait_cycles), 16'(2 * (P + R) + 1));

    // R5 reads
    base = rd_idx;
    acc(0, 1, 3'd0, 16'h0000);
    chk("R5 wide read data", bus_rdata, 16'hC33C);
    acc(0, 0, 3'd0, 16'h0000);
    chk("R5 byte read data", bus_rdata, 16'h0077);
    chk("R5 read pulses", 16'(rd_idx - base), 16'd3);

    // R6 monitors
    chk("R6 pulse widths", 16'(bad_width), 16'd0);
    chk("R6 oe during read", 16'(oe_on_read), 16'd0);
    chk("R6 strobes overlap", 16'(both_low), 16'd0);

    // R7 request during wait is ignored
    @(negedge clk);
    bus_req = 1; bus_we = 1; bus_wide = 1; bus_addr = 3'd0; bus_wdata = 16'h1111;
    @(negedge clk);
    bus_addr = 3'd4; bus_wdata = 16'h0000; bus_wide = 0;
    @(negedge clk);
    bus_req = 0;
    while (bus_wait) @(negedge clk);
    acc(0, 0, 3'd4, 16'h0000);
    chk("R7 ignored mode write", bus_rdata, 16'h0094);

    // R8 busy status
    nf_rb = 0;
    repeat (4) @(negedge clk);
    acc(0, 0, 3'd5, 16'h0000);
    chk("R8 busy", bus_rdata, 16'h0080);
    acc(0, 0, 3'd6, 16'h0000);
    chk("R9 no flag while busy", bus_rdata, 16'h0000);
    nf_rb = 1;
    repeat (4) @(negedge clk);
    acc(0, 0, 3'd5, 16'h0000);
    chk("R8 ready", bus_rdata, 16'h0000);
    acc(0, 0, 3'd6, 16'h0000);
    chk("R9 flag set", bus_rdata, 16'h0001);

    // R10 mask gating (mask currently 0x01)
    repeat (2) @(negedge clk);
    chk("R10 irq masked 0x01", 16'(irq), 16'd0);
    acc(1, 0, 3'd7, 16'h0081);
    repeat (2) @(negedge clk);
    chk("R10 irq enabled 0x81", 16'(irq), 16'd1);
    acc(1, 0, 3'd7, 16'h0080);
    repeat (2) @(negedge clk);
    chk("R10 irq masked 0x80", 16'(irq), 16'd0);
    acc(1, 0, 3'd7, 16'h0081);
    acc(1, 0, 3'd6, 16'h000F);
    acc(0, 0, 3'd6, 16'h0000);
    chk("R9 cleared by 0x0F", bus_rdata, 16'h0000);
    repeat (2) @(negedge clk);
    chk("R10 irq after clear", 16'(irq), 16'd0);

    // R11 power
    acc(1, 0, 3'd4, 16'h000C);
    chk("R11 power on", 16'(nf_pwr_en), 16'd1);
    acc(1, 0, 3'd4, 16'h0094);
    chk("R11 power kept", 16'(nf_pwr_en), 16'd1);
    acc(1, 0, 3'd4, 16'h0008);
    chk("R11 power off", 16'(nf_pwr_en), 16'd0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule